// File: doc/BRIEF.md
# C2-Flag Sample Concealment

This block sits after error correction in an audio playback path. It takes one word per channel per beat, each word carrying a flag that says it could not be corrected, and it hides the damage before the samples reach the output stage. A short burst of flagged words is filled with the mean of the last clean word before the burst and the first clean word after it. A long burst, or a burst with no clean word behind it since reset, is silenced to zero. Each channel keeps its own history and makes its own decision.

Every channel holds a five-entry delay line, so the concealment window is four samples plus one. The length of a burst is therefore known before its first word leaves. Each channel runs a three-state machine. `ST_PASS` forwards clean words. On a flagged head word it takes either `PASS->INTERP` (the burst is short and a clean word exists behind it) or `PASS->MUTE` (the burst fills the whole window, or there is no history). `ST_INTERP` repeats the captured mean for the rest of the burst. `ST_MUTE` emits zeros for the rest of the burst. `INTERP->PASS` and `MUTE->PASS` are taken when the next clean word reaches the head. The input is a valid/ready stream. The output is a valid-only stream with one conceal bit per channel.

Top module: `c2_conceal`

## Requirements
- R1: A word whose flag is 0 leaves unchanged, with its conceal bit at 0.
- R2: The first five accepted beats produce no output. After that, every accepted beat produces exactly one output beat, which carries the beat accepted five beats earlier, with out_valid high in the cycle after the accepting edge.
- R3: Take a flagged burst of 1 to 3 words. If a clean word precedes it since reset, every word of the burst is output as floor((prev_clean + next_clean)/2), in signed 16-bit arithmetic, with conceal 1.
- R4: Every word of a flagged burst of 4 or more words is output as 0 with conceal 1, including bursts longer than the delay line.
- R5: Every word of a flagged burst that starts at the first word after reset is output as 0 with conceal 1, whatever its length.
- R6: Channel 0 occupies in_data[15:0] and in_flag[0], and channel 1 occupies in_data[31:16] and in_flag[1]. The flags and data of one channel never change the output of the other.
- R7: The mean rounds toward negative infinity. For example, neighbours -3 and 0 give -2. The sum does not overflow for full-scale neighbours.
- R8: While reset is held, in_ready and out_valid are 0. From the first cycle after reset in_ready is 1.
- R9: A cycle with in_valid low neither advances the delay line nor produces output, whatever in_data and in_flag hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 32 | One signed 16-bit word per channel |
| in_flag | input | 2 | Uncorrectable flag per channel |
| out_valid | output | 1 | Output beat present |
| out_data | output | 32 | Concealed word per channel |
| out_conceal | output | 2 | Word was replaced, per channel |

## Verification
An output beat is due exactly one clock after the edge that accepts the sixth and each later input beat. The bench logs every accepting edge. On each falling edge it compares out_valid with "an accept happened at the last edge and more than five have happened in total". It compares the data only on beats where out_valid is high, and it indexes the expected stream by output count, so the cycles of an input stall shift nothing. The expected words come from a model that measures the full burst length and its neighbours over the whole stimulus stream.

// File: rtl/c2c_pkg.sv
package c2c_pkg;
    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,
        ST_INTERP = 2'd1,
        ST_MUTE   = 2'd2
    } conceal_st_e;
endpackage

// File: rtl/cm_delay_line.sv
module cm_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift,
    input  logic [W-1:0]              din,
    input  logic                      fin,
    output logic [DEPTH-1:0][W-1:0]   line_data,
    output logic [DEPTH-1:0]          line_flag
);
    // index 0 is the oldest word; new words enter at DEPTH-1
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == DEPTH - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    line_data[k] <= '0;
                    line_flag[k] <= 1'b0;
                end else if (shift) begin
                    line_data[k] <= din;
                    line_flag[k] <= fin;
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    line_data[k] <= '0;
                    line_flag[k] <= 1'b0;
                end else if (shift) begin
                    line_data[k] <= line_data[k+1];
                    line_flag[k] <= line_flag[k+1];
                end
            end
        end
    end
endmodule

// File: rtl/cm_run_detect.sv
module cm_run_detect #(
    parameter int DEPTH = 5,
    parameter int WIN   = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] flags,
    output logic             run_long,
    output logic [IW-1:0]    next_idx
);
    // a burst filling the whole window selects muting
    assign run_long = &flags[WIN-1:0];

    // nearest clean word behind the head
    always_comb begin
        next_idx = '0;
        for (int k = DEPTH - 1; k >= 1; k--) begin
            if (!flags[k]) next_idx = IW'(k);
        end
    end
endmodule

// File: rtl/cm_chan_fsm.sv
module cm_chan_fsm
    import c2c_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 5,
    parameter int WIN   = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     emit,
    input  logic [DEPTH-1:0][W-1:0]  line_data,
    input  logic [DEPTH-1:0]         line_flag,
    output logic [W-1:0]             out_data,
    output logic                     out_conceal
);
    conceal_st_e        st_q, st_d;
    logic [W-1:0]       last_good_q;
    logic               have_good_q;
    logic [W-1:0]       avg_q;
    logic [W-1:0]       res;
    logic [W-1:0]       avg_new;
    logic signed [W:0]  pair_sum;
    logic               run_long;
    logic [IW-1:0]      next_idx;
    logic [W-1:0]       head_d;
    logic               head_f;

    cm_run_detect #(.DEPTH(DEPTH), .WIN(WIN)) u_det (
        .flags    (line_flag),
        .run_long (run_long),
        .next_idx (next_idx)
    );

    assign head_d = line_data[0];
    assign head_f = line_flag[0];

    // widened sum, then arithmetic halving: floor rounding
    assign pair_sum = $signed({last_good_q[W-1], last_good_q})
                    + $signed({line_data[next_idx][W-1], line_data[next_idx]});
    assign avg_new  = pair_sum[W:1];

    always_comb begin
        st_d = st_q;
        res  = head_d;
        unique case (st_q)
            ST_PASS: begin
                if (head_f) begin
                    if (run_long || !have_good_q) begin
                        st_d = ST_MUTE;
                        res  = '0;
                    end else begin
                        st_d = ST_INTERP;
                        res  = avg_new;
                    end
                end
            end
            ST_INTERP: begin
                if (head_f) res = avg_q;
                else        st_d = ST_PASS;
            end
            ST_MUTE: begin
                if (head_f) res = '0;
                else        st_d = ST_PASS;
            end
            default: begin
                st_d = ST_PASS;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= ST_PASS;
        else if (emit) st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data    <= '0;
            out_conceal <= 1'b0;
            last_good_q <= '0;
            have_good_q <= 1'b0;
            avg_q       <= '0;
        end else if (emit) begin
            out_data    <= res;
            out_conceal <= head_f;
            if (!head_f) begin
                last_good_q <= head_d;
                have_good_q <= 1'b1;
            end
            if (st_q == ST_PASS && head_f) avg_q <= avg_new;
        end
    end

    // R1
    a_r1_clean_passes: assert property (@(posedge clk) disable iff (!rst_n)
        emit && !head_f |=> out_data == $past(head_d) && !out_conceal);
    // R4
    a_r4_long_run_zero: assert property (@(posedge clk) disable iff (!rst_n)
        emit && head_f && run_long && st_q == ST_PASS |=> out_data == '0 && out_conceal);
    // R5
    a_r5_no_history_zero: assert property (@(posedge clk) disable iff (!rst_n)
        emit && head_f && !have_good_q |=> out_data == '0);
    // R3
    a_r3_interp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        emit && head_f && st_q == ST_INTERP |=> out_data == $past(avg_q));
endmodule

// File: rtl/c2_conceal.sv
module c2_conceal #(
    parameter int NCH   = 2,
    parameter int W     = 16,
    parameter int WIN   = 4,
    localparam int DEPTH = WIN + 1,
    localparam int FW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NCH*W-1:0]  in_data,
    input  logic [NCH-1:0]    in_flag,
    output logic              out_valid,
    output logic [NCH*W-1:0]  out_data,
    output logic [NCH-1:0]    out_conceal
);
    logic          rdy_q;
    logic [FW-1:0] fill_q;
    logic          acc;
    logic          emit;

    assign in_ready = rdy_q;
    assign acc      = in_valid && rdy_q;
    assign emit     = acc && (fill_q == FW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q     <= 1'b0;
            fill_q    <= '0;
            out_valid <= 1'b0;
        end else begin
            rdy_q     <= 1'b1;
            out_valid <= emit;
            if (acc && fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DEPTH-1:0][W-1:0] ld;
        logic [DEPTH-1:0]        lf;

        cm_delay_line #(.W(W), .DEPTH(DEPTH)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift     (acc),
            .din       (in_data[c*W +: W]),
            .fin       (in_flag[c]),
            .line_data (ld),
            .line_flag (lf)
        );

        cm_chan_fsm #(.W(W), .DEPTH(DEPTH), .WIN(WIN)) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .emit        (emit),
            .line_data   (ld),
            .line_flag   (lf),
            .out_data    (out_data[c*W +: W]),
            .out_conceal (out_conceal[c])
        );
    end

    // R2, R9: output only follows an accepted beat
    a_r2_out_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready));
    // R9: idle cycle yields no output next cycle
    a_r9_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: tb/sim_c2_conceal.sv
module sim_c2_conceal;
    localparam int CLK_NS = 10;
    localparam int N      = 1200;
    localparam int DEPTH  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [1:0]  in_flag = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [1:0]  out_conceal;

    int vals [2][N];
    bit flg  [2][N];
    int expv [2][N];
    string tagv [2][N];

    int checks = 0, fails = 0;
    int acc_cnt = 0, out_idx = 0, cycles = 0;
    bit last_acc = 0, monitor_on = 0;

    c2_conceal u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_flag(in_flag), .out_valid(out_valid),
        .out_data(out_data), .out_conceal(out_conceal)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(bit ok, string req, int act, int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        last_acc <= in_valid && in_ready && rst_n;
        if (in_valid && in_ready && rst_n) acc_cnt <= acc_cnt + 1;
    end

    always @(negedge clk) begin
        if (cycles > 200000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            finish_run();
        end
        if (monitor_on) begin
            // R2 / R9: output timing
            check(out_valid == (last_acc && acc_cnt > DEPTH), "R2/R9 out_valid",
                  int'(out_valid), int'(last_acc && acc_cnt > DEPTH));
            if (out_valid && out_idx < N) begin
                for (int c = 0; c < 2; c++) begin
                    int act;
                    act = int'($signed(out_data[c*16 +: 16]));
                    check(act == expv[c][out_idx], tagv[c][out_idx], act, expv[c][out_idx]);
                    check(out_conceal[c] == flg[c][out_idx], {tagv[c][out_idx], " conceal"},
                          int'(out_conceal[c]), int'(flg[c][out_idx]));
                end
                out_idx++;
            end
        end
    end

    function automatic int wrap16(int v);
        logic [15:0] t;
        t = v[15:0];
        return int'($signed(t));
    endfunction

    initial begin
        // ---- stimulus construction ----
        for (int c = 0; c < 2; c++) begin
            int i, r, g;
            i = 0;
            if (c == 0) begin
                // burst at stream start (R5), then rounding case (R7)
                flg[0][0] = 1; flg[0][1] = 1; flg[0][2] = 1;
                flg[0][3] = 0; flg[0][4] = 1; flg[0][5] = 0;
                i = 6;
            end
            r = (c == 0) ? 1 : 7;
            g = 1;
            while (i < N) begin
                for (int k = 0; k < g && i < N; k++) begin flg[c][i] = 0; i++; end
                for (int k = 0; k < r && i < N; k++) begin flg[c][i] = 1; i++; end
                if (c == 0) begin r = (r == 7) ? 1 : r + 1; g = (g == 3) ? 1 : g + 1; end
                else        begin r = (r == 1) ? 7 : r - 1; g = (g == 1) ? 3 : g - 1; end
            end
            for (int j = 0; j < N; j++) begin
                if (c == 0) vals[0][j] = wrap16(j * 2731 + 17);
                else        vals[1][j] = wrap16(32767 - j * 4093);
                if (j % 50 == 7) vals[c][j] = 32767;
                if (j % 50 == 9) vals[c][j] = -32768;
            end
        end
        vals[0][3] = -3; vals[0][5] = 0;

        // ---- expected values from the requirements ----
        for (int c = 0; c < 2; c++) begin
            for (int j = 0; j < N; j++) begin
                string pre;
                pre = (c == 1) ? "R6/" : "";
                if (!flg[c][j]) begin
                    expv[c][j] = vals[c][j];
                    tagv[c][j] = {pre, "R1 clean"};
                end else begin
                    int s, e, len, sum;
                    s = j; while (s > 0 && flg[c][s-1]) s--;
                    e = j; while (e < N - 1 && flg[c][e+1]) e++;
                    len = e - s + 1;
                    if (s == 0) begin
                        expv[c][j] = 0; tagv[c][j] = {pre, "R5 no history"};
                    end else if (len >= 4) begin
                        expv[c][j] = 0; tagv[c][j] = {pre, "R4 long mute"};
                    end else if (e + 1 < N) begin
                        sum = vals[c][s-1] + vals[c][e+1];
                        expv[c][j] = sum >>> 1;
                        tagv[c][j] = (sum < 0 && (sum % 2) != 0) ? {pre, "R7 floor"} : {pre, "R3 mean"};
                    end else begin
                        expv[c][j] = 0; tagv[c][j] = {pre, "tail"};
                    end
                end
            end
        end

        // ---- reset (R8) ----
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R8 ready in reset", int'(in_ready), 0);
        check(out_valid == 1'b0, "R8 valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R8 ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R8 valid after reset", int'(out_valid), 0);
        monitor_on = 1;

        // ---- drive stream with stalls carrying junk (R9) ----
        for (int j = 0; j < N; j++) begin
            in_valid = 1'b1;
            in_data  = {vals[1][j][15:0], vals[0][j][15:0]};
            in_flag  = {flg[1][j], flg[0][j]};
            @(negedge clk);
            if (j % 7 == 3) begin
                in_valid = 1'b0;
                in_data  = 32'hDEAD_BEEF ^ 32'(j);
                in_flag  = 2'b11;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(out_idx == N - DEPTH, "R2 output count", out_idx, N - DEPTH);
        finish_run();
    end
endmodule